// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Unit

This unit collects four active-low interrupt requests and tells the processor which one to serve. One request is non-maskable and always outranks the rest. The other three are maskable levels ranked below it. Whenever an eligible request exists, the unit raises a request line and drives the fixed vector address of the winning source. The processor answers with a one-cycle acknowledge. That acknowledge consumes the winning request and clears the global enable.

The host controls the maskable levels in two ways. It writes a per-level mask, where a 1 blocks the level, and it sets or clears a global enable that gates all maskable levels. A parameter picks, per maskable input, whether it latches on a falling edge or follows its level. By default the highest maskable level is edge-latched and the other two are level-sensitive. The non-maskable input is accepted only after a falling edge, and only while the input then stays low. A status word gives the host the mask, the global enable and the raw pending flags in one read.

Every request input passes through one register stage before it is used. A level input can therefore raise the request line one clock after it goes low. An edge-latched input needs two clocks.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset, `int_req` is 0, `int_vec` is 0 and `stat` is 7'h07: all three levels masked, global enable 0, nothing pending. Whenever `int_req` is 0, `int_vec` is 0.
- R2: A falling edge on `top_req_n` with the input then held low raises `int_req` with vector 8'h24. This happens whatever the mask and global enable are. After it is acknowledged, a `top_req_n` that stays low does not request again until a new falling edge.
- R3: If `top_req_n` returns high before acknowledge, the non-maskable request is withdrawn, and `int_req` falls on the next clock.
- R4: Priority from highest to lowest is: non-maskable, level 2, level 1, level 0. The vectors are 8'h24, 8'h3C, 8'h34 and 8'h2C respectively. Only the highest eligible source is presented.
- R5: A maskable level is eligible only when its mask bit (`cfg_wdata[i]` as last written, 1 = blocked) is 0 and the global enable is 1.
- R6: Level 2 is latched on a falling edge of `lvl_req_n[2]`. It stays pending after the input returns high, until its acknowledge or until a write with `cfg_wdata[3]` = 1. A write with `cfg_wdata[3]` = 0 leaves it pending.
- R7: Levels 1 and 0 are pending only while their input is low. Releasing the input withdraws the request on the next clock.
- R8: An acknowledge while `int_req` is 1 clears the global enable, and clears the latched request of the source being served.
- R9: The bit fields of `stat` are as follows. Bits [2:0] hold the mask. Bit [3] holds the global enable. Bits [6:4] hold the pending flags of levels 0, 1 and 2; these flags are shown regardless of mask or enable.
- R10: `int_ack` while `int_req` is 0 changes nothing.
- R11: An acknowledge takes precedence over an `en_set` in the same cycle, so the enable ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| top_req_n | input | 1 | Non-maskable request, active low |
| lvl_req_n | input | NLVL (3) | Maskable requests, active low; bit 2 is the highest |
| en_set | input | 1 | Pulse: set the global enable |
| en_clr | input | 1 | Pulse: clear the global enable |
| cfg_we | input | 1 | Write strobe for the mask word |
| cfg_wdata | input | NLVL+1 (4) | [2:0] new mask (1 = blocked); [3] = 1 also drops latched edge requests |
| int_ack | input | 1 | Processor acknowledge, one cycle |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | VW (8) | Vector address of the presented source, 0 when idle |
| stat | output | 2*NLVL+1 (7) | Status word {pending[2:0], enable, mask[2:0]} |

## Verification
The main test is a sweep over every combination of the four request lines, the eight mask values and both enable states. For each combination the bench compares the presented vector, the request line and the status word against a priority choice it computes itself. This separates ordering errors, mask-polarity errors and enable-gating errors, and it shows that the non-maskable source ignores both controls. Directed sequences then check the behaviours that depend on timing:
- a non-maskable pulse released early;
- a non-maskable input held low across its acknowledge;
- a level-2 pulse that outlives its input;
- clearing level 2 by a write, with and without the clear bit;
- level withdrawal on levels 1 and 0;
- a stray acknowledge while idle;
- an acknowledge that collides with an enable set.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

    // Which kind of source currently wins arbitration.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_TOP  = 2'd1,
        WIN_LVL  = 2'd2
    } win_kind_e;

    // Width of an index into NLVL levels; never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prio_irq_sampler.sv
`timescale 1ns/1ps
// Registers the active-low request pins as active-high and flags the
// cycle in which each one has just become active.
module prio_irq_sampler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_n,
    output logic [W-1:0] act,
    output logic [W-1:0] fall
);
    logic [W-1:0] smp_d, smp_q;
    logic [W-1:0] prv_d, prv_q;

    always_comb begin
        smp_d = ~raw_n;
        prv_d = smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
            prv_q <= '0;
        end else begin
            smp_q <= smp_d;
            prv_q <= prv_d;
        end
    end

    assign act  = smp_q;
    assign fall = smp_q & ~prv_q;
endmodule

// File: rtl/prio_irq_resolver.sv
`timescale 1ns/1ps
// Pure combinational choice of the winning source and its vector.
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int                       NLVL    = 3,
    parameter int                       VW      = 8,
    parameter logic [VW-1:0]            VEC_TOP = 8'h24,
    parameter logic [NLVL-1:0][VW-1:0]  VEC_LVL = {8'h3C, 8'h34, 8'h2C},
    localparam int                      IDXW    = idx_width(NLVL)
) (
    input  logic            top_hit,
    input  logic [NLVL-1:0] lvl_elig,
    output win_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic [VW-1:0]   vec
);
    always_comb begin
        kind = WIN_NONE;
        idx  = '0;
        vec  = '0;
        // Ascending scan: a later (higher) index overrides a lower one.
        for (int i = 0; i < NLVL; i++) begin
            if (lvl_elig[i]) begin
                kind = WIN_LVL;
                idx  = IDXW'(i);
                vec  = VEC_LVL[i];
            end
        end
        if (top_hit) begin
            kind = WIN_TOP;
            idx  = '0;
            vec  = VEC_TOP;
        end
    end
endmodule

// File: rtl/prio_irq_unit.sv
`timescale 1ns/1ps
module prio_irq_unit
    import prio_irq_pkg::*;
#(
    parameter int                       NLVL       = 3,
    parameter int                       VW         = 8,
    parameter logic [VW-1:0]            VEC_TOP    = 8'h24,
    parameter logic [NLVL-1:0][VW-1:0]  VEC_LVL    = {8'h3C, 8'h34, 8'h2C},
    parameter logic [NLVL-1:0]          EDGE_SENSE = 3'b100,
    localparam int                      STW        = 2*NLVL + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            top_req_n,
    input  logic [NLVL-1:0] lvl_req_n,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic            cfg_we,
    input  logic [NLVL:0]   cfg_wdata,
    input  logic            int_ack,
    output logic            int_req,
    output logic [VW-1:0]   int_vec,
    output logic [STW-1:0]  stat
);
    localparam int IDXW = idx_width(NLVL);

    typedef struct packed {
        logic [NLVL-1:0] mask;
        logic            gie;
        logic            top_lat;
        logic [NLVL-1:0] edge_lat;
    } state_t;

    state_t st_d, st_q;

    logic [NLVL:0]     act, fall;
    logic [NLVL-1:0]   lvl_pend, lvl_elig;
    logic              top_hit, take;
    win_kind_e         kind;
    logic [IDXW-1:0]   idx;

    prio_irq_sampler #(.W(NLVL+1)) i_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n ({top_req_n, lvl_req_n}),
        .act   (act),
        .fall  (fall)
    );

    // Per-level sensing variant chosen by parameter.
    for (genvar g = 0; g < NLVL; g++) begin : g_sense
        if (EDGE_SENSE[g]) begin : g_edge
            assign lvl_pend[g] = st_q.edge_lat[g];
        end else begin : g_level
            assign lvl_pend[g] = act[g];
        end
    end

    assign top_hit  = st_q.top_lat & act[NLVL];
    assign lvl_elig = lvl_pend & ~st_q.mask & {NLVL{st_q.gie}};

    prio_irq_resolver #(
        .NLVL    (NLVL),
        .VW      (VW),
        .VEC_TOP (VEC_TOP),
        .VEC_LVL (VEC_LVL)
    ) i_resolver (
        .top_hit  (top_hit),
        .lvl_elig (lvl_elig),
        .kind     (kind),
        .idx      (idx),
        .vec      (int_vec)
    );

    assign int_req = (kind != WIN_NONE);
    assign take    = int_ack & int_req;

    always_comb begin
        st_d = st_q;
        if (en_clr) st_d.gie = 1'b0;
        if (en_set) st_d.gie = 1'b1;
        if (cfg_we) begin
            st_d.mask = cfg_wdata[NLVL-1:0];
            if (cfg_wdata[NLVL]) st_d.edge_lat = '0;
        end
        // The non-maskable latch survives only while the pin stays active.
        if (!act[NLVL]) st_d.top_lat = 1'b0;
        if (take) begin
            st_d.gie = 1'b0;
            if (kind == WIN_TOP) st_d.top_lat = 1'b0;
            else                 st_d.edge_lat[idx] = 1'b0;
        end
        // A fresh edge in the same cycle counts as a new event.
        st_d.edge_lat = st_d.edge_lat | (fall[NLVL-1:0] & EDGE_SENSE);
        if (fall[NLVL]) st_d.top_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = {lvl_pend, st_q.gie, st_q.mask};
endmodule

// File: rtl/prio_irq_chk.sv
`timescale 1ns/1ps
module prio_irq_chk #(
    parameter int                       NLVL       = 3,
    parameter int                       VW         = 8,
    parameter logic [VW-1:0]            VEC_TOP    = 8'h24,
    parameter logic [NLVL-1:0][VW-1:0]  VEC_LVL    = {8'h3C, 8'h34, 8'h2C},
    parameter logic [NLVL-1:0]          EDGE_SENSE = 3'b100,
    localparam int                      STW        = 2*NLVL + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           int_req,
    input logic           int_ack,
    input logic [VW-1:0]  int_vec,
    input logic [STW-1:0] stat,
    input logic           cfg_we,
    input logic           clr_edge
);
    logic [NLVL-1:0] avail;
    assign avail = stat[STW-1:NLVL+1] & ~stat[NLVL-1:0];

    p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req |-> int_vec == '0);

    p_ack_clears_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_req && int_ack |=> !stat[NLVL]);

    p_en_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_req && int_vec != VEC_TOP |-> stat[NLVL]);

    for (genvar i = 0; i < NLVL; i++) begin : g_lvl
        p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            int_req && int_vec == VEC_LVL[i] |-> !stat[i] && stat[NLVL+1+i]);

        p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            int_req && int_vec == VEC_LVL[i] |-> (avail >> (i+1)) == '0);

        if (EDGE_SENSE[i]) begin : g_edge
            p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                stat[NLVL+1+i] && !(int_req && int_ack && int_vec == VEC_LVL[i])
                && !(cfg_we && clr_edge) |=> stat[NLVL+1+i]);
        end
    end
endmodule

bind prio_irq_unit prio_irq_chk #(
    .NLVL       (NLVL),
    .VW         (VW),
    .VEC_TOP    (VEC_TOP),
    .VEC_LVL    (VEC_LVL),
    .EDGE_SENSE (EDGE_SENSE)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_req  (int_req),
    .int_ack  (int_ack),
    .int_vec  (int_vec),
    .stat     (stat),
    .cfg_we   (cfg_we),
    .clr_edge (cfg_wdata[NLVL])
);

// File: tb/test_prio_irq_unit.sv
`timescale 1ns/1ps
module test_prio_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       top_req_n = 1'b1;
    logic [2:0] lvl_req_n = 3'b111;
    logic       en_set = 1'b0, en_clr = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       int_ack = 1'b0;
    logic       int_req;
    logic [7:0] int_vec;
    logic [6:0] stat;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    prio_irq_unit i_prio_irq_unit (
        .clk(clk), .rst_n(rst_n), .top_req_n(top_req_n), .lvl_req_n(lvl_req_n),
        .en_set(en_set), .en_clr(en_clr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .int_ack(int_ack), .int_req(int_req), .int_vec(int_vec), .stat(stat)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] d);
        cfg_we = 1'b1; cfg_wdata = d; step(1); cfg_we = 1'b0;
    endtask

    task automatic pulse_set(); en_set = 1'b1; step(1); en_set = 1'b0; endtask
    task automatic pulse_clr(); en_clr = 1'b1; step(1); en_clr = 1'b0; endtask
    task automatic pulse_ack(); int_ack = 1'b1; step(1); int_ack = 1'b0; endtask

    function automatic logic [7:0] exp_vec(input logic t, input logic [2:0] r,
                                           input logic [2:0] m, input logic g);
        logic [7:0] tbl [3];
        tbl[0] = 8'h2C; tbl[1] = 8'h34; tbl[2] = 8'h3C;
        if (t) return 8'h24;
        for (int j = 2; j >= 0; j--)
            if (r[j] && !m[j] && g) return tbl[j];
        return 8'h00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 int_req", int_req, 0);
        chk("R1 int_vec", int_vec, 0);
        chk("R1 stat", stat, 7'h07);

        // Sweep R4 R5 R9 R2: all requests x masks x enable
        for (int c = 0; c < 256; c++) begin
            logic t, g;
            logic [2:0] r, m;
            logic [7:0] ev;
            t = c[7]; r = c[6:4]; m = c[3:1]; g = c[0];
            ev = exp_vec(t, r, m, g);
            wr_cfg({1'b1, m});
            if (g) pulse_set(); else pulse_clr();
            top_req_n = ~t; lvl_req_n = ~r;
            step(2);
            chk("R4/R5/R2 int_vec", int_vec, ev);
            chk("R1/R4 int_req", int_req, (ev != 0));
            chk("R9 stat", stat, {r, g, m});
            top_req_n = 1'b1; lvl_req_n = 3'b111;
            step(2);
        end

        wr_cfg(4'b1000);
        pulse_set();

        // R3 non-maskable pulse released early
        top_req_n = 1'b0; step(2);
        chk("R3 vec before release", int_vec, 8'h24);
        top_req_n = 1'b1; step(1);
        chk("R3 withdrawn", int_req, 0);
        step(3);
        chk("R3 stays withdrawn", int_req, 0);

        // R2 held low across acknowledge needs a new edge
        top_req_n = 1'b0; step(2);
        chk("R2 vec", int_vec, 8'h24);
        pulse_ack();
        chk("R2 consumed", int_req, 0);
        chk("R8 enable cleared", stat[3], 0);
        step(3);
        chk("R2 no re-request without edge", int_req, 0);
        top_req_n = 1'b1; step(2);

        // R6 level 2 latched past input release, then acknowledged
        pulse_set();
        lvl_req_n[2] = 1'b0; step(2);
        lvl_req_n[2] = 1'b1; step(2);
        chk("R6 latched vec", int_vec, 8'h3C);
        chk("R6 pending flag", stat[6], 1);
        pulse_ack();
        chk("R6/R8 cleared by ack", int_req, 0);
        chk("R6 pending dropped", stat[6], 0);
        chk("R8 enable cleared", stat[3], 0);

        // R6 write without and with the clear bit
        pulse_set();
        lvl_req_n[2] = 1'b0; step(2);
        lvl_req_n[2] = 1'b1; step(2);
        wr_cfg(4'b0000);
        chk("R6 write without clear keeps", stat[6], 1);
        chk("R6 still requesting", int_vec, 8'h3C);
        wr_cfg(4'b1000);
        chk("R6 write with clear drops", stat[6], 0);
        chk("R6 request gone", int_req, 0);

        // R7 level-sensitive withdrawal
        lvl_req_n[1] = 1'b0; step(2);
        chk("R7 level1 vec", int_vec, 8'h34);
        lvl_req_n[1] = 1'b1; step(1);
        chk("R7 level1 withdrawn", int_req, 0);
        chk("R7 level1 flag", stat[5], 0);
        lvl_req_n[0] = 1'b0; step(1);
        chk("R7 level0 vec", int_vec, 8'h2C);
        lvl_req_n[0] = 1'b1; step(1);
        chk("R7 level0 withdrawn", int_req, 0);

        // R10 stray acknowledge while idle
        pulse_ack();
        chk("R10 enable kept", stat[3], 1);
        chk("R10 no request", int_req, 0);
        chk("R10 stat", stat, 7'h08);

        // R11 acknowledge beats simultaneous enable set
        lvl_req_n[0] = 1'b0; step(2);
        chk("R11 pre vec", int_vec, 8'h2C);
        en_set = 1'b1; int_ack = 1'b1; step(1);
        en_set = 1'b0; int_ack = 1'b0;
        chk("R11 enable cleared", stat[3], 0);
        chk("R11 request gated", int_req, 0);
        lvl_req_n[0] = 1'b1; step(2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule